// File: doc/BRIEF.md
# Cascaded Master Clock Prescaler

This block turns a free-running master clock into a slower internal clock, expressed as a one-cycle enable pulse rather than a new clock net. Three programmable divider stages sit in series. The first two divide by 1, 2 or 3, and the last divides by 1, 2 or 4, so the overall ratio is any product of those choices, from 1 up to 36. Downstream logic runs on the master clock and does its work only in cycles where the internal enable is high.

On top of the internal enable, the block counts internal periods and raises two rate strobes. The normal sample strobe fires once every 256 internal periods. The low-latency sample strobe fires once every 128 internal periods. Both strobes coincide with an internal enable pulse.

The divider setting is an 8-bit input that may change at any time. The block adopts a new setting only at a sample-strobe boundary. At that point every stage counter restarts from zero, so each sample period is built from a single ratio and the pulse spacing stays exact.

Top module: `mcdiv_top`

## Requirements
- R1: While `rst` is high, `ick_en`, `smp_stb` and `lgd_stb` are low and all stages fall back to divide-by-1. In the first cycle after `rst` falls, `ick_en` is high.
- R2: The first stage is set by `div_cfg[1:0]` and the second by `div_cfg[3:2]`, with 00 = /1, 01 = /2, 10 = /3 and 11 = /1.
- R3: The third stage is set by `div_cfg[5:4]`, with 00 = /1, 01 = /2, 10 = /4 and 11 = /1.
- R4: `div_cfg[7:6]` has no effect on any output.
- R5: `ick_en` is a single-cycle pulse that repeats exactly every D master cycles, where D is the product of the three active stage ratios.
- R6: `smp_stb` rises on every 256th `ick_en` pulse, in the same cycle as that pulse, and never on two consecutive cycles.
- R7: `lgd_stb` rises on every 128th `ick_en` pulse, in the same cycle as that pulse. Every `smp_stb` cycle is also an `lgd_stb` cycle.
- R8: A new `div_cfg` value is adopted only in the cycle that produces `smp_stb`. The first `ick_en` after that strobe comes exactly D_new cycles later, and a change made mid-period leaves the current period untouched.
- R9: The setting `div_cfg` = 8'h06 (stage ratios /3, /2, /1) gives D = 6, so `smp_stb` repeats every 1536 master cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| div_cfg | input | 8 | Divider setting: three 2-bit stage codes in bits 5:0; bits 7:6 are spare |
| ick_en | output | 1 | Internal clock enable, one cycle per internal period |
| smp_stb | output | 1 | Sample strobe, once per 256 internal periods |
| lgd_stb | output | 1 | Low-latency sample strobe, once per 128 internal periods |

## Verification
The bench builds the block with its default parameters: three stages, an 8-bit setting, and strobe ratios of 256 and 128. These defaults give overall ratios from 1 to 36 and sample periods up to 9216 master cycles, so every stage code and the longest chain of divide-by-3 and divide-by-4 fit within the run.

Setting changes land at random points inside a sample period. This tests that the old ratio holds until the boundary and that the first pulse after the boundary uses the new ratio. Directed settings cover:
- the 8'h06 case,
- the all-ones code,
- the maximum ratio,
- a setting with the spare bits set.

// File: rtl/mcdiv_pkg.sv
package mcdiv_pkg;

  localparam int FLD_W = 2;

  // Ratio family of a stage: {1,2,3} or {1,2,4}
  typedef enum logic {KIND_TRI, KIND_POW} stg_kind_e;

  // Terminal count (ratio - 1) for a stage code; unused code means pass-through
  function automatic logic [FLD_W-1:0] lim_of(stg_kind_e kind, logic [FLD_W-1:0] code);
    logic [FLD_W-1:0] lim;
    case (code)
      2'b01:   lim = 2'd1;
      2'b10:   lim = (kind == KIND_POW) ? 2'd3 : 2'd2;
      default: lim = 2'd0;
    endcase
    return lim;
  endfunction

endpackage

// File: rtl/mcdiv_stage.sv
module mcdiv_stage
  import mcdiv_pkg::*;
#(
  parameter stg_kind_e KIND = KIND_TRI
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             en_in,
  input  logic [FLD_W-1:0] code,
  output logic             en_out
);

  logic [FLD_W-1:0] cnt;
  logic [FLD_W-1:0] lim;

  assign lim    = lim_of(KIND, code);
  assign en_out = en_in && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (en_in) begin
      cnt <= (cnt == lim) ? '0 : FLD_W'(cnt + 1'b1);
    end
  end

endmodule

// File: rtl/mcdiv_rate.sv
module mcdiv_rate #(
  parameter int SMP_DIV = 256,
  parameter int LGD_DIV = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic bnd,
  output logic lgd_hit
);

  localparam int CW = $clog2(SMP_DIV);
  localparam logic [CW-1:0] SMP_LAST = CW'(SMP_DIV - 1);
  localparam logic [CW-1:0] LGD_MASK = CW'(LGD_DIV - 1);

  logic [CW-1:0] cnt;

  assign bnd     = tick && (cnt == SMP_LAST);
  assign lgd_hit = tick && ((cnt & LGD_MASK) == LGD_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= bnd ? '0 : CW'(cnt + 1'b1);
    end
  end

endmodule

// File: rtl/mcdiv_top.sv
module mcdiv_top
  import mcdiv_pkg::*;
#(
  parameter int NSTG    = 3,
  parameter int CFG_W   = 8,
  parameter int SMP_DIV = 256,
  parameter int LGD_DIV = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] div_cfg,
  output logic             ick_en,
  output logic             smp_stb,
  output logic             lgd_stb
);

  localparam int ACT_W = NSTG * FLD_W;

  logic [ACT_W-1:0] act_cfg;
  logic [NSTG:0]    en_chain;
  logic             bnd;
  logic             lgd_hit;

  assign en_chain[0] = 1'b1;

  generate
    for (genvar i = 0; i < NSTG; i++) begin : g_stg
      localparam stg_kind_e K = (i == NSTG - 1) ? KIND_POW : KIND_TRI;
      mcdiv_stage #(.KIND(K)) u_stg (
        .clk     (clk),
        .rst     (rst),
        .restart (bnd),
        .en_in   (en_chain[i]),
        .code    (act_cfg[i*FLD_W +: FLD_W]),
        .en_out  (en_chain[i+1])
      );
    end
    if (CFG_W > ACT_W) begin : g_spare
      logic cfg_spare_unused;
      assign cfg_spare_unused = ^div_cfg[CFG_W-1:ACT_W];
    end
  endgenerate

  mcdiv_rate #(.SMP_DIV(SMP_DIV), .LGD_DIV(LGD_DIV)) u_rate (
    .clk     (clk),
    .rst     (rst),
    .tick    (en_chain[NSTG]),
    .bnd     (bnd),
    .lgd_hit (lgd_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      act_cfg <= '0;
      ick_en  <= 1'b0;
      smp_stb <= 1'b0;
      lgd_stb <= 1'b0;
    end else begin
      if (bnd) act_cfg <= div_cfg[ACT_W-1:0];
      ick_en  <= en_chain[NSTG];
      smp_stb <= bnd;
      lgd_stb <= lgd_hit;
    end
  end

endmodule

// File: rtl/mcdiv_chk.sv
module mcdiv_chk #(
  parameter int ACT_W   = 6,
  parameter int MAX_GAP = 36
) (
  input logic             clk,
  input logic             rst,
  input logic             ick_en,
  input logic             smp_stb,
  input logic             lgd_stb,
  input logic [ACT_W-1:0] act_cfg
);

  // cycles since the last internal enable pulse, saturating
  logic [7:0] gap;

  always_ff @(posedge clk) begin
    if (rst)              gap <= '0;
    else if (ick_en)      gap <= 8'd1;
    else if (gap != 8'hFF) gap <= gap + 8'd1;
  end

  assert_rst_quiet_R1: assert property (@(posedge clk)
    rst |=> (!ick_en && !smp_stb && !lgd_stb));

  assert_gap_bound_R5: assert property (@(posedge clk) disable iff (rst)
    gap <= 8'(MAX_GAP));

  assert_smp_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
    smp_stb |-> ick_en);

  assert_smp_single_R6: assert property (@(posedge clk) disable iff (rst)
    smp_stb |=> !smp_stb);

  // R7: low-latency strobe rides on an enable pulse and covers every sample strobe
  assert_lgd_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
    lgd_stb |-> ick_en);

  assert_smp_implies_lgd_R7: assert property (@(posedge clk) disable iff (rst)
    smp_stb |-> lgd_stb);

  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_cfg) |-> smp_stb);

endmodule

bind mcdiv_top mcdiv_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .ick_en  (ick_en),
  .smp_stb (smp_stb),
  .lgd_stb (lgd_stb),
  .act_cfg (act_cfg)
);

// File: tb/sim_mcdiv_top.sv
`timescale 1ns/1ps
module sim_mcdiv_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cfg = 8'h2A;
  logic       ick_en, smp_stb, lgd_stb;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  mcdiv_top u0 (
    .clk     (clk),
    .rst     (rst),
    .div_cfg (cfg),
    .ick_en  (ick_en),
    .smp_stb (smp_stb),
    .lgd_stb (lgd_stb)
  );

  function automatic int dfun(logic [7:0] c);
    int a, b, d;
    a = (c[1:0] == 2'b01) ? 2 : (c[1:0] == 2'b10) ? 3 : 1;
    b = (c[3:2] == 2'b01) ? 2 : (c[3:2] == 2'b10) ? 3 : 1;
    d = (c[5:4] == 2'b01) ? 2 : (c[5:4] == 2'b10) ? 4 : 1;
    return a * b * d;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // cycle count and the setting seen at each rising edge
  int         cyc = 0;
  logic [7:0] cfg_at_edge = 8'h00;
  always @(posedge clk) begin
    cyc         <= cyc + 1;
    cfg_at_edge <= cfg;
  end

  // monitor state
  int         exp_d = 1;
  logic [7:0] epoch_cfg = 8'h00;
  bit         have_ick = 0, have_smp = 0, have_lgd = 0, after_bnd = 0;
  int         last_ick = 0, last_smp = 0, last_lgd = 0, ick_cnt = 0;
  int         smp_seen = 0;

  always @(negedge clk) begin
    if (rst) begin
      check(!ick_en && !smp_stb && !lgd_stb, "R1 reset quiet",
            {29'd0, ick_en, smp_stb, lgd_stb}, 0);
      exp_d = 1; epoch_cfg = 8'h00;
      have_ick = 0; have_smp = 0; have_lgd = 0; after_bnd = 0; ick_cnt = 0;
    end else begin
      if (ick_en) begin
        if (have_ick) begin
          string t;
          if (after_bnd)                 t = "R8 first pulse after boundary";
          else if (epoch_cfg[7:6] != 0)  t = "R4 spare bits ignored";
          else if (epoch_cfg[5:4] != 0)  t = "R3 third stage ratio";
          else                           t = "R2 R5 enable spacing";
          check(cyc - last_ick == exp_d, t, cyc - last_ick, exp_d);
        end
        have_ick = 1; last_ick = cyc; ick_cnt++; after_bnd = 0;
      end
      if (lgd_stb) begin
        check(ick_en == 1'b1, "R7 lgd on enable", int'(ick_en), 1);
        if (have_lgd)
          check(cyc - last_lgd == 128 * exp_d, "R7 lgd spacing", cyc - last_lgd, 128 * exp_d);
        have_lgd = 1; last_lgd = cyc;
      end
      if (smp_stb) begin
        check(ick_en == 1'b1, "R6 smp on enable", int'(ick_en), 1);
        check(lgd_stb == 1'b1, "R7 smp implies lgd", int'(lgd_stb), 1);
        check(ick_cnt == 256, "R6 pulses per sample", ick_cnt, 256);
        if (have_smp) begin
          check(cyc - last_smp == 256 * exp_d, "R6 smp spacing", cyc - last_smp, 256 * exp_d);
          if (epoch_cfg == 8'h06)
            check(cyc - last_smp == 1536, "R9 /3 /2 /1 period", cyc - last_smp, 1536);
        end
        have_smp = 1; last_smp = cyc; ick_cnt = 0; smp_seen++;
        epoch_cfg = cfg_at_edge;
        exp_d = dfun(cfg_at_edge);
        after_bnd = 1;
      end
    end
  end

  task automatic wait_smp();
    int start;
    start = smp_seen;
    while (smp_seen == start) @(negedge clk);
  endtask

  task automatic epoch(logic [7:0] c);
    int off;
    off = $urandom % 200;
    repeat (off) @(negedge clk);
    #1 cfg = c;
    wait_smp();
  endtask

  initial begin
    int seed_val;
    seed_val = $urandom(32'd7);
    repeat (5) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(ick_en == 1'b1, "R1 enable right after reset", int'(ick_en), 1);
    @(negedge clk);
    check(ick_en == 1'b1, "R1 divide-by-1 default", int'(ick_en), 1);

    epoch(8'h06);   // R9: /3 /2 /1
    epoch(8'hFF);   // R2 R3 R4: all-ones codes give /1
    epoch(8'h2A);   // R3: maximum ratio 36
    epoch(8'h15);   // /2 /2 /2
    epoch(8'hC9);   // R4: spare bits set, /2 /3 /1
    for (int i = 0; i < 6; i++) epoch(8'($urandom));
    epoch(8'h00);
    wait_smp();     // full period under the last setting
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    finish_run();
  end

endmodule